// File: doc/BRIEF.md
# Program Status Word Carry/Overflow/Half-Carry Update Unit

This block decides how the carry (C), signed overflow (OV) and half-carry (AC) bits of an 8-bit accumulator machine's status word change when an instruction retires. The core presents an operation code, the accumulator, the second operand, the B register, the current flag values and, for the boolean carry forms, a single bit operand with an invert select. One clock later the unit returns the next value of each flag and a write enable per flag. A flag that the instruction leaves alone keeps its old value, and its write enable stays low.

The unit follows a fixed per-instruction rule. Some flags are forced to a constant, some are derived from the arithmetic, and the rest are untouched. Multiply and divide always clear carry and derive overflow from the operands. Decimal adjust, the two rotates through carry, compare-and-jump and every carry-bit boolean form write carry only. Result bytes, register storage and branch decisions belong to the surrounding datapath. Only the arithmetic needed to form the flags is computed here.

Top module: `psw_flag_unit`

## Requirements
- R1: With op 1 (add) or op 2 (add with carry-in taken from c_old), C is the carry out of bit 7, AC is the carry out of bit 3, OV is set when two operands of equal sign give a result of the other sign, and all three write enables are high.
- R2: With op 3 (subtract with borrow c_old), C is the borrow out of bit 7, AC is the borrow out of bit 3, OV is set when acc and opnd differ in sign and the result's sign differs from acc, and all three write enables are high.
- R3: With op 4 (multiply acc by breg), C is 0, OV is 1 exactly when the 16-bit product exceeds 255, C and OV are written, and AC is not written.
- R4: With op 5 (divide acc by breg), C is 0, OV is 1 exactly when breg is zero, C and OV are written, and AC is not written.
- R5: With op 6 (decimal adjust), a low digit above 9 or a set ac_old adds 6, and then a high digit above 9 or a pending carry adds 0x60. C becomes 1 if either add carries out of bit 7 and otherwise keeps c_old.
- R6: Op 7 (rotate right through carry) loads C from acc bit 0. Op 8 (rotate left through carry) loads C from acc bit 7.
- R7: With op 9 (compare and jump), C is 1 exactly when acc is unsigned-less-than opnd.
- R8: Op 10 sets C to 0, op 11 sets C to 1, and op 12 inverts c_old.
- R9: Op 13 gives C = c_old AND b, and op 14 gives C = c_old OR b, where b is bit_val inverted when bit_inv is 1. Op 15 copies bit_val into C and ignores bit_inv.
- R10: A flag that the op does not affect (including every flag under op 0, no operation) appears at the output with its old input value and its write enable low. Ops 6 to 15 never write OV or AC.
- R11: Results appear exactly one cycle after in_valid. A cycle without in_valid gives out_valid low and all write enables low. Reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 4 | Operation code (values in R1 to R10) |
| acc | input | DW | Accumulator |
| opnd | input | DW | Second operand |
| breg | input | DW | B register (multiply/divide) |
| c_old | input | 1 | Current carry |
| ov_old | input | 1 | Current overflow |
| ac_old | input | 1 | Current half-carry |
| bit_val | input | 1 | Bit operand for the carry boolean ops |
| bit_inv | input | 1 | Use the inverted bit operand (ops 13, 14) |
| out_valid | output | 1 | Flag update valid |
| c_new | output | 1 | Next carry |
| ov_new | output | 1 | Next overflow |
| ac_new | output | 1 | Next half-carry |
| c_we | output | 1 | Carry write enable |
| ov_we | output | 1 | Overflow write enable |
| ac_we | output | 1 | Half-carry write enable |

## Verification
The unit holds only one stage of state, so an internal fault shows at the ports on the cycle right after the instruction that triggers it. A wrong carry chain, a wrong nibble boundary or a wrong sign test gives a flag value that differs from an independent integer model for that single vector. A wrong enable or pass-through path shows up as an OV or AC value that changed under a carry-only op, or as an enable pulse in an idle cycle. The bench therefore looks for boundary operands at 0x7F/0x80, 0xFF/0x00, nibble 9/10 and product 255/256.

// File: rtl/psw_flag_pkg.sv
package psw_flag_pkg;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUBB  = 4'd3,
    OP_MUL   = 4'd4,
    OP_DIV   = 4'd5,
    OP_DA    = 4'd6,
    OP_RRC   = 4'd7,
    OP_RLC   = 4'd8,
    OP_CJNE  = 4'd9,
    OP_CLRC  = 4'd10,
    OP_SETBC = 4'd11,
    OP_CPLC  = 4'd12,
    OP_ANLC  = 4'd13,
    OP_ORLC  = 4'd14,
    OP_MOVC  = 4'd15
  } op_e;

  // value and enable for each of the three flags
  typedef struct packed {
    logic c;
    logic ov;
    logic ac;
    logic c_we;
    logic ov_we;
    logic ac_we;
  } flag_upd_t;

endpackage

// File: rtl/psw_arith_flags.sv
module psw_arith_flags
  import psw_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e             op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   o,
  input  logic [DW-1:0]   breg,
  input  logic            cin,
  output flag_upd_t       upd,
  output logic            mul_ovf,
  output logic            div_zero
);
  localparam int NIB = DW / 2;
  localparam int MSB = DW - 1;

  // returns {carry, overflow, half}
  function automatic logic [2:0] add_eval(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                          input logic ci);
    logic [DW:0]  s;
    logic [NIB:0] lo;
    s  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    lo = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, ci};
    return {s[DW], (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]), lo[NIB]};
  endfunction

  // returns {borrow, overflow, half borrow}
  function automatic logic [2:0] sub_eval(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                          input logic bi);
    logic [DW:0]  d;
    logic [NIB:0] lo;
    d  = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, bi};
    lo = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - {{NIB{1'b0}}, bi};
    return {d[DW], (x[MSB] != y[MSB]) && (d[MSB] != x[MSB]), lo[NIB]};
  endfunction

  function automatic logic prod_exceeds(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
    return p > {{DW{1'b0}}, {DW{1'b1}}};
  endfunction

  logic [2:0] add_res;
  logic [2:0] sub_res;

  assign add_res  = add_eval(a, o, (op == OP_ADDC) ? cin : 1'b0);
  assign sub_res  = sub_eval(a, o, cin);
  assign mul_ovf  = prod_exceeds(a, breg);
  assign div_zero = (breg == '0);

  always_comb begin
    upd = '0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        {upd.c, upd.ov, upd.ac}          = add_res;
        {upd.c_we, upd.ov_we, upd.ac_we} = 3'b111;
      end
      OP_SUBB: begin
        {upd.c, upd.ov, upd.ac}          = sub_res;
        {upd.c_we, upd.ov_we, upd.ac_we} = 3'b111;
      end
      OP_MUL: begin
        upd.ov    = mul_ovf;
        upd.c_we  = 1'b1;
        upd.ov_we = 1'b1;
      end
      OP_DIV: begin
        upd.ov    = div_zero;
        upd.c_we  = 1'b1;
        upd.ov_we = 1'b1;
      end
      default: upd = '0;
    endcase
  end

endmodule

// File: rtl/psw_carry_logic.sv
module psw_carry_logic
  import psw_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] o,
  input  logic          cin,
  input  logic          acin,
  input  logic          bit_val,
  input  logic          bit_inv,
  output logic          c_nxt,
  output logic          c_wr,
  output logic          da_carry,
  output logic          bit_eff
);
  localparam int NIB = DW / 2;
  localparam logic [DW:0]     LO_FIX = (DW+1)'(6);
  localparam logic [DW:0]     HI_FIX = LO_FIX << NIB;
  localparam logic [NIB-1:0]  DIGIT_MAX = NIB'(9);

  // decimal adjust: carry out of the two correction adds
  function automatic logic da_eval(input logic [DW-1:0] x, input logic ci, input logic hi);
    logic [DW:0] t1;
    logic [DW:0] t2;
    logic        lo_need;
    logic        hi_need;
    lo_need = (x[NIB-1:0] > DIGIT_MAX) || hi;
    t1      = {1'b0, x} + (lo_need ? LO_FIX : '0);
    hi_need = (t1[DW-1:NIB] > DIGIT_MAX) || ci || t1[DW];
    t2      = {1'b0, t1[DW-1:0]} + (hi_need ? HI_FIX : '0);
    return ci | t1[DW] | t2[DW];
  endfunction

  assign da_carry = da_eval(a, cin, acin);
  assign bit_eff  = bit_val ^ bit_inv;

  always_comb begin
    c_nxt = cin;
    c_wr  = 1'b1;
    unique case (op)
      OP_DA:    c_nxt = da_carry;
      OP_RRC:   c_nxt = a[0];
      OP_RLC:   c_nxt = a[DW-1];
      OP_CJNE:  c_nxt = (a < o);
      OP_CLRC:  c_nxt = 1'b0;
      OP_SETBC: c_nxt = 1'b1;
      OP_CPLC:  c_nxt = ~cin;
      OP_ANLC:  c_nxt = cin & bit_eff;
      OP_ORLC:  c_nxt = cin | bit_eff;
      OP_MOVC:  c_nxt = bit_val;
      default:  c_wr  = 1'b0;
    endcase
  end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] breg,
  input  logic          c_old,
  input  logic          ov_old,
  input  logic          ac_old,
  input  logic          bit_val,
  input  logic          bit_inv,
  output logic          out_valid,
  output logic          c_new,
  output logic          ov_new,
  output logic          ac_new,
  output logic          c_we,
  output logic          ov_we,
  output logic          ac_we
);
  op_e       op_q;
  flag_upd_t arith_upd;
  flag_upd_t nxt;
  logic      mul_ovf;
  logic      div_zero;
  logic      carry_c;
  logic      carry_wr;
  logic      da_carry;
  logic      bit_eff;
  logic      sel_arith;

  assign op_q = op_e'(op);

  psw_arith_flags #(.DW(DW)) u_arith (
    .op(op_q), .a(acc), .o(opnd), .breg(breg), .cin(c_old),
    .upd(arith_upd), .mul_ovf(mul_ovf), .div_zero(div_zero)
  );

  psw_carry_logic #(.DW(DW)) u_carry (
    .op(op_q), .a(acc), .o(opnd), .cin(c_old), .acin(ac_old),
    .bit_val(bit_val), .bit_inv(bit_inv),
    .c_nxt(carry_c), .c_wr(carry_wr), .da_carry(da_carry), .bit_eff(bit_eff)
  );

  assign sel_arith = arith_upd.c_we;

  // merge: untouched flags pass their old value through
  always_comb begin
    nxt.c_we  = sel_arith | carry_wr;
    nxt.ov_we = arith_upd.ov_we;
    nxt.ac_we = arith_upd.ac_we;
    nxt.c     = sel_arith ? arith_upd.c : (carry_wr ? carry_c : c_old);
    nxt.ov    = nxt.ov_we ? arith_upd.ov : ov_old;
    nxt.ac    = nxt.ac_we ? arith_upd.ac : ac_old;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      c_new     <= 1'b0;
      ov_new    <= 1'b0;
      ac_new    <= 1'b0;
      c_we      <= 1'b0;
      ov_we     <= 1'b0;
      ac_we     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      c_we      <= in_valid & nxt.c_we;
      ov_we     <= in_valid & nxt.ov_we;
      ac_we     <= in_valid & nxt.ac_we;
      if (in_valid) begin
        c_new  <= nxt.c;
        ov_new <= nxt.ov;
        ac_new <= nxt.ac;
      end
    end
  end

endmodule

// File: rtl/psw_flag_chk.sv
module psw_flag_chk
  import psw_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] opnd,
  input logic [DW-1:0] breg,
  input logic          c_old,
  input logic          ov_old,
  input logic          ac_old,
  input logic          out_valid,
  input logic          c_new,
  input logic          ov_new,
  input logic          ac_new,
  input logic          c_we,
  input logic          ov_we,
  input logic          ac_we,
  input logic          mul_ovf
);
  logic carry_only;
  assign carry_only = (op >= 4'(OP_DA));

  p_mul_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_MUL |=> c_we && !c_new && ov_we && !ac_we
      && ov_new == $past(mul_ovf) && ac_new == $past(ac_old));

  p_div_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_DIV |=> c_we && !c_new && ov_we && !ac_we
      && ov_new == ($past(breg) == '0));

  p_cjne_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_CJNE |=> c_we && c_new == ($past(acc) < $past(opnd)));

  p_setb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_SETBC |=> c_we && c_new);

  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_CLRC |=> c_we && !c_new);

  p_carry_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && carry_only |=> !ov_we && !ac_we
      && ov_new == $past(ov_old) && ac_new == $past(ac_old));

  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_NONE |=> out_valid && !c_we && !ov_we && !ac_we
      && c_new == $past(c_old));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !c_we && !ov_we && !ac_we);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  always_comb begin
    if (rst_n && !out_valid) begin
      p_no_we_idle_r11: assert (!(c_we || ov_we || ac_we));
    end
  end

endmodule

bind psw_flag_unit psw_flag_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
  .opnd(opnd), .breg(breg), .c_old(c_old), .ov_old(ov_old), .ac_old(ac_old),
  .out_valid(out_valid), .c_new(c_new), .ov_new(ov_new), .ac_new(ac_new),
  .c_we(c_we), .ov_we(ov_we), .ac_we(ac_we), .mul_ovf(mul_ovf)
);

// File: tb/test_psw_flag_unit.sv
`timescale 1ns/1ps
module test_psw_flag_unit;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [3:0]    op = '0;
  logic [DW-1:0] acc = '0, opnd = '0, breg = '0;
  logic          c_old = 1'b0, ov_old = 1'b0, ac_old = 1'b0;
  logic          bit_val = 1'b0, bit_inv = 1'b0;
  logic          out_valid, c_new, ov_new, ac_new, c_we, ov_we, ac_we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  psw_flag_unit #(.DW(DW)) i_psw_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
    .opnd(opnd), .breg(breg), .c_old(c_old), .ov_old(ov_old), .ac_old(ac_old),
    .bit_val(bit_val), .bit_inv(bit_inv), .out_valid(out_valid),
    .c_new(c_new), .ov_new(ov_new), .ac_new(ac_new),
    .c_we(c_we), .ov_we(ov_we), .ac_we(ac_we)
  );

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // integer reference model: {c, ov, ac, c_we, ov_we, ac_we}
  function automatic logic [5:0] model(input int o_p, input int a, input int d, input int b,
                                       input int ci, input int ovi, input int aci,
                                       input int bv, input int bi);
    int c, ov, ac, cw, ow, aw, sr, t, k, bb;
    c = ci; ov = ovi; ac = aci; cw = 0; ow = 0; aw = 0;
    bb = (bi != 0) ? 1 - bv : bv;
    case (o_p)
      1, 2: begin
        k = (o_p == 2) ? ci : 0;
        c = (a + d + k > 255) ? 1 : 0;
        ac = ((a % 16) + (d % 16) + k > 15) ? 1 : 0;
        sr = sx(a) + sx(d) + k;
        ov = (sr > 127 || sr < -128) ? 1 : 0;
        cw = 1; ow = 1; aw = 1;
      end
      3: begin
        c = (a < d + ci) ? 1 : 0;
        ac = ((a % 16) < (d % 16) + ci) ? 1 : 0;
        sr = sx(a) - sx(d) - ci;
        ov = (sr > 127 || sr < -128) ? 1 : 0;
        cw = 1; ow = 1; aw = 1;
      end
      4: begin c = 0; ov = (a * b > 255) ? 1 : 0; cw = 1; ow = 1; end
      5: begin c = 0; ov = (b == 0) ? 1 : 0; cw = 1; ow = 1; end
      6: begin
        t = a;
        if ((a % 16) > 9 || aci != 0) t = t + 6;
        if (t > 255) c = 1;
        t = t % 256;
        if ((t / 16) > 9 || c != 0) t = t + 96;
        if (t > 255) c = 1;
        cw = 1;
      end
      7:  begin c = a % 2; cw = 1; end
      8:  begin c = a / 128; cw = 1; end
      9:  begin c = (a < d) ? 1 : 0; cw = 1; end
      10: begin c = 0; cw = 1; end
      11: begin c = 1; cw = 1; end
      12: begin c = 1 - ci; cw = 1; end
      13: begin c = ci & bb; cw = 1; end
      14: begin c = ci | bb; cw = 1; end
      15: begin c = bv; cw = 1; end
      default: ;
    endcase
    return {c[0], ov[0], ac[0], cw[0], ow[0], aw[0]};
  endfunction

  function automatic string tag_of(input int o_p);
    case (o_p)
      1, 2:   return "R1";
      3:      return "R2";
      4:      return "R3";
      5:      return "R4";
      6:      return "R5";
      7, 8:   return "R6";
      9:      return "R7";
      10, 11, 12: return "R8";
      13, 14, 15: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic send(input int o_p, input int a, input int d, input int b,
                      input int ci, input int ovi, input int aci,
                      input int bv, input int bi);
    @(negedge clk);
    in_valid = 1'b1;
    op = o_p[3:0]; acc = a[7:0]; opnd = d[7:0]; breg = b[7:0];
    c_old = ci[0]; ov_old = ovi[0]; ac_old = aci[0];
    bit_val = bv[0]; bit_inv = bi[0];
    exp_q.push_back(model(o_p, a, d, b, ci, ovi, aci, bv, bi));
    tag_q.push_back(tag_of(o_p));
  endtask

  // idle cycles with junk on the operand inputs (R11)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op = 4'd11; acc = 8'hFF; c_old = 1'b1; ov_old = 1'b1; ac_old = 1'b1;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R11 unexpected out_valid, actual=1 expected=0");
        end else begin
          logic [5:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({c_new, ov_new, ac_new, c_we, ov_we, ac_we} !== e) begin
            failures++;
            $display("FAIL %s {c,ov,ac,cwe,owe,awe} actual=%b expected=%b", t,
                     {c_new, ov_new, ac_new, c_we, ov_we, ac_we}, e);
          end
        end
      end else begin
        checks++;
        if (c_we || ov_we || ac_we || exp_q.size() > 1) begin
          failures++;
          $display("FAIL R11 idle cycle enables actual=%b expected=000 (pending=%0d)",
                   {c_we, ov_we, ac_we}, exp_q.size());
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, c_new, ov_new, ac_new, c_we, ov_we, ac_we} !== 7'b0) begin
      failures++;
      $display("FAIL R11 reset outputs actual=%b expected=0000000",
               {out_valid, c_new, ov_new, ac_new, c_we, ov_we, ac_we});
    end
    rst_n = 1'b1;
    idle(2);

    // R1 sign and carry boundaries
    send(1, 8'h7F, 8'h01, 0, 0, 0, 0, 0, 0);
    send(1, 8'hFF, 8'h01, 0, 0, 1, 0, 0, 0);
    send(2, 8'h80, 8'h7F, 0, 1, 0, 0, 0, 0);
    send(2, 8'h80, 8'h80, 0, 0, 0, 1, 0, 0);
    // R2 borrow boundaries
    send(3, 8'h00, 8'h01, 0, 0, 0, 0, 0, 0);
    send(3, 8'h80, 8'h01, 0, 0, 0, 0, 0, 0);
    send(3, 8'h10, 8'h0F, 0, 1, 1, 1, 0, 0);
    idle(1);
    // R3 product 256 vs 255, AC kept
    send(4, 8'h10, 0, 8'h10, 1, 0, 1, 0, 0);
    send(4, 8'h0F, 0, 8'h11, 1, 1, 0, 0, 0);
    // R4 divide by zero vs non-zero
    send(5, 8'h33, 0, 8'h00, 1, 0, 1, 0, 0);
    send(5, 8'h33, 0, 8'h03, 1, 1, 0, 0, 0);
    // R5 decimal adjust corners
    send(6, 8'h9A, 0, 0, 0, 0, 0, 0, 0);
    send(6, 8'h45, 0, 0, 0, 1, 1, 0, 0);
    send(6, 8'h12, 0, 0, 1, 0, 0, 0, 0);
    send(6, 8'hFA, 0, 0, 0, 0, 0, 0, 0);
    // R6 rotates
    send(7, 8'h01, 0, 0, 0, 1, 1, 0, 0);
    send(8, 8'h7F, 0, 0, 1, 0, 1, 0, 0);
    // R7 compare: less, equal, greater
    send(9, 8'h10, 8'h11, 0, 0, 0, 0, 0, 0);
    send(9, 8'h11, 8'h11, 0, 1, 1, 0, 0, 0);
    send(9, 8'hF0, 8'h0F, 0, 1, 0, 1, 0, 0);
    idle(2);
    // R8 carry forcing
    send(10, 0, 0, 0, 1, 1, 1, 0, 0);
    send(11, 0, 0, 0, 0, 0, 0, 0, 0);
    send(12, 0, 0, 0, 1, 0, 1, 0, 0);
    // R9 boolean forms with invert
    send(13, 0, 0, 0, 1, 0, 0, 0, 1);
    send(13, 0, 0, 0, 1, 1, 1, 1, 1);
    send(14, 0, 0, 0, 0, 0, 0, 0, 1);
    send(14, 0, 0, 0, 0, 1, 0, 1, 1);
    send(15, 0, 0, 0, 0, 0, 1, 1, 1);
    send(15, 0, 0, 0, 1, 1, 0, 0, 1);
    // R10 no operation passes flags through
    send(0, 8'hFF, 8'hFF, 0, 1, 0, 1, 1, 1);

    // mixed random coverage of every op
    for (int i = 0; i < 400; i++) begin
      send($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 255),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R11 results missing actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule